// File: doc/BRIEF.md
# Link Inactivity Timeout and Session Watchdog Supervisor

This block watches the decoded event strobes of a single-wire, half-duplex device port and decides when the port must drop back into its low-power sleep state. It does not decode bits or run commands. It receives one-cycle strobes from the token decoder and the command engine, and it returns a one-cycle `force_sleep_o` pulse when the link has lost synchronization or a session has lasted too long.

Two counters run in clock cycles. The inter-token timeout is armed only while the port is waiting for something. Those waits are the first token after wake, the remainder of a token whose leading edge was seen, and the data bits of a command after its command flag. The timeout restarts on every legal token, so a long command passes as long as no single gap is too long. An illegal token stops those restarts. The session watchdog starts at wake and cannot be restarted except by going to sleep and waking again.

`awake_o` reports whether a session is open. `cause_tmo_o` and `cause_wdg_o` record which counter ended the last forced sleep. Both causes are recorded when both counters expire together.

Top module: `link_sleep_supervisor`

## Requirements
- R1: A `wake_i` strobe sampled while asleep sets `awake_o` at that clock edge and starts a session. A `wake_i` strobe sampled while awake has no effect and does not restart the watchdog.
- R2: If no `tok_ok_i` is sampled at any of the first TMO_CYCLES edges after the wake edge, `force_sleep_o` pulses at edge TMO_CYCLES after the wake edge. A `tok_ok_i` at or before that edge prevents this pulse.
- R3: Every `tok_ok_i` restarts the timeout count. While a command is being received, gaps of at most TMO_CYCLES cycles between legal tokens never cause a sleep, whatever the total command length. A gap longer than that causes a sleep TMO_CYCLES edges after the last restart.
- R4: A `cmd_flag_i` strobe arms the timeout until a `last_bit_i` strobe. A `tok_start_i` strobe arms it until the next `tok_ok_i`. Outside these windows, once the first legal token has arrived, the timeout does not fire.
- R5: After a `tok_bad_i` strobe, later `tok_ok_i` strobes no longer restart the count. `force_sleep_o` pulses TMO_CYCLES edges after the `tok_bad_i` edge.
- R6: While `busy_i` is high the timeout neither counts nor fires.
- R7: `force_sleep_o` pulses at edge WDG_CYCLES after the wake edge, even while busy, while tokens keep arriving, or during a command.
- R8: `sleep_req_i` while awake clears `awake_o` at that edge with no `force_sleep_o` pulse. A later wake starts a fresh watchdog interval counted from the new wake edge.
- R9: `force_sleep_o` is high for exactly one cycle per forced sleep, and `awake_o` is low from that same edge. `cause_tmo_o` and `cause_wdg_o` are set to 1 for each counter that expired at that edge, so both are set on a simultaneous expiry. Both causes are cleared to 0 by the next accepted wake.
- R10: While asleep, every strobe other than `wake_i` is ignored. No pulse occurs, `awake_o` stays 0, and both counters are held at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wake_i | input | 1 | Wake token recognized |
| tok_start_i | input | 1 | Leading edge of a data token seen |
| tok_ok_i | input | 1 | Legal token completed |
| tok_bad_i | input | 1 | Illegal token (overlong low pulse) |
| cmd_flag_i | input | 1 | Legal command flag received |
| last_bit_i | input | 1 | Last expected command data bit received |
| busy_i | input | 1 | Command engine executing |
| sleep_req_i | input | 1 | Sleep flag from host |
| force_sleep_o | output | 1 | One-cycle forced-sleep pulse |
| awake_o | output | 1 | Session open |
| cause_tmo_o | output | 1 | Last forced sleep came from the timeout |
| cause_wdg_o | output | 1 | Last forced sleep came from the watchdog |

## Verification
The assertions assume that reset is held for at least one edge and that every input is a clean one-cycle strobe or level sampled at the rising edge. They make no assumption about how the strobes are ordered. The pulse-shape and sleep-state properties therefore hold for any stimulus. The bench drives inputs only at the falling edge, one session at a time, and always starts from sleep. It sweeps the first-token delay and the inter-token gap across and past TMO_CYCLES in a small configuration (TMO_CYCLES=5, WDG_CYCLES=40). For every session it computes the exact expected firing edge from the requirement arithmetic.

// File: rtl/sup_pkg.sv
package sup_pkg;
  typedef struct packed {
    logic tmo;
    logic wdg;
  } sleep_cause_t;

  function automatic int cnt_width(input int len);
    return (len < 2) ? 1 : $clog2(len + 1);
  endfunction
endpackage

// File: rtl/sup_timer.sv
module sup_timer #(
  parameter int LEN = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic hit
);
  localparam int W = sup_pkg::cnt_width(LEN);
  localparam logic [W-1:0] LAST = W'(LEN - 1);

  logic [W-1:0] cnt_q;

  assign hit = ~clr & (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
    end else if (!hit) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R3: the count never runs past its terminal value
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST);

  // R10: a cleared timer starts from zero on the next cycle
  assert_clear_zero_R10: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt_q == '0));
endmodule

// File: rtl/sup_arm.sv
module sup_arm (
  input  logic clk,
  input  logic rst,
  input  logic awake,
  input  logic wake_go,
  input  logic sleep_go,
  input  logic tok_start,
  input  logic tok_ok,
  input  logic tok_bad,
  input  logic cmd_flag,
  input  logic last_bit,
  input  logic busy,
  output logic armed,
  output logic restart
);
  logic first_wait_q;
  logic tok_pend_q;
  logic cmd_rx_q;
  logic bad_q;

  always_ff @(posedge clk) begin
    if (rst || sleep_go || (!awake && !wake_go)) begin
      first_wait_q <= 1'b0;
      tok_pend_q   <= 1'b0;
      cmd_rx_q     <= 1'b0;
      bad_q        <= 1'b0;
    end else if (wake_go) begin
      first_wait_q <= 1'b1;
      tok_pend_q   <= 1'b0;
      cmd_rx_q     <= 1'b0;
      bad_q        <= 1'b0;
    end else begin
      if (tok_ok) first_wait_q <= 1'b0;
      tok_pend_q <= tok_start | (tok_pend_q & ~tok_ok);
      cmd_rx_q   <= cmd_flag  | (cmd_rx_q & ~last_bit);
      if (tok_bad) bad_q <= 1'b1;
    end
  end

  assign restart = tok_ok & ~tok_bad & ~bad_q;
  assign armed   = (first_wait_q | tok_pend_q | cmd_rx_q | bad_q) & ~busy;

  // R5: once an illegal token is latched no legal token restarts the count
  assert_bad_no_restart_R5: assert property (@(posedge clk) disable iff (rst)
    (awake && !sleep_go && tok_bad) |=> !restart);

  // R10: nothing stays armed once the port is asleep
  assert_asleep_disarmed_R10: assert property (@(posedge clk) disable iff (rst)
    (!awake && !wake_go) |=> !armed);
endmodule

// File: rtl/link_sleep_supervisor.sv
module link_sleep_supervisor #(
  parameter int TMO_CYCLES = 2000,
  parameter int WDG_CYCLES = 1000000
) (
  input  logic clk,
  input  logic rst,
  input  logic wake_i,
  input  logic tok_start_i,
  input  logic tok_ok_i,
  input  logic tok_bad_i,
  input  logic cmd_flag_i,
  input  logic last_bit_i,
  input  logic busy_i,
  input  logic sleep_req_i,
  output logic force_sleep_o,
  output logic awake_o,
  output logic cause_tmo_o,
  output logic cause_wdg_o
);
  import sup_pkg::*;

  logic awake_q, force_q;
  sleep_cause_t cause_q;
  logic wake_go, sleep_go;
  logic armed, restart;
  logic tmo_hit, wdg_hit, tmo_clr;

  assign wake_go  = wake_i & ~awake_q;
  assign sleep_go = awake_q & (sleep_req_i | tmo_hit | wdg_hit);
  assign tmo_clr  = ~awake_q | ~armed | restart;

  sup_arm u_arm (
    .clk       (clk),
    .rst       (rst),
    .awake     (awake_q),
    .wake_go   (wake_go),
    .sleep_go  (sleep_go),
    .tok_start (tok_start_i),
    .tok_ok    (tok_ok_i),
    .tok_bad   (tok_bad_i),
    .cmd_flag  (cmd_flag_i),
    .last_bit  (last_bit_i),
    .busy      (busy_i),
    .armed     (armed),
    .restart   (restart)
  );

  sup_timer #(.LEN(TMO_CYCLES)) u_tmo (
    .clk (clk),
    .rst (rst),
    .clr (tmo_clr),
    .hit (tmo_hit)
  );

  sup_timer #(.LEN(WDG_CYCLES)) u_wdg (
    .clk (clk),
    .rst (rst),
    .clr (~awake_q),
    .hit (wdg_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      awake_q <= 1'b0;
      force_q <= 1'b0;
      cause_q <= '0;
    end else begin
      force_q <= awake_q & (tmo_hit | wdg_hit);
      if (wake_go) begin
        awake_q <= 1'b1;
        cause_q <= '0;
      end else if (sleep_go) begin
        awake_q <= 1'b0;
        if (tmo_hit || wdg_hit) begin
          cause_q.tmo <= tmo_hit;
          cause_q.wdg <= wdg_hit;
        end
      end
    end
  end

  assign force_sleep_o = force_q;
  assign awake_o       = awake_q;
  assign cause_tmo_o   = cause_q.tmo;
  assign cause_wdg_o   = cause_q.wdg;

  // R9: a forced sleep is a single-cycle pulse
  assert_single_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    force_sleep_o |=> !force_sleep_o);

  // R9: the port is asleep whenever the pulse is out, with a cause recorded
  assert_pulse_asleep_R9: assert property (@(posedge clk) disable iff (rst)
    force_sleep_o |-> (!awake_o && (cause_tmo_o || cause_wdg_o)));

  // R1: a wake seen while asleep opens a session
  assert_wake_opens_R1: assert property (@(posedge clk) disable iff (rst)
    (!awake_o && wake_i) |=> awake_o);

  // R6: a busy engine never produces a timeout expiry
  assert_busy_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    busy_i |-> !tmo_hit);

  // R10: an idle sleeping port stays asleep and silent
  assert_asleep_idle_R10: assert property (@(posedge clk) disable iff (rst)
    (!awake_o && !wake_i) |=> (!awake_o && !force_sleep_o));

  // R8: a host sleep request never produces a forced pulse by itself
  assert_req_no_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    (awake_o && sleep_req_i && !tmo_hit && !wdg_hit) |=> !force_sleep_o);
endmodule

// File: tb/test_link_sleep_supervisor.sv
`timescale 1ns/1ps
module test_link_sleep_supervisor;
  localparam int TMO = 5;
  localparam int WDG = 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wake_i = 0, tok_start_i = 0, tok_ok_i = 0, tok_bad_i = 0;
  logic cmd_flag_i = 0, last_bit_i = 0, busy_i = 0, sleep_req_i = 0;
  logic force_sleep_o, awake_o, cause_tmo_o, cause_wdg_o;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  link_sleep_supervisor #(.TMO_CYCLES(TMO), .WDG_CYCLES(WDG)) i_link_sleep_supervisor (
    .clk(clk), .rst(rst), .wake_i(wake_i), .tok_start_i(tok_start_i),
    .tok_ok_i(tok_ok_i), .tok_bad_i(tok_bad_i), .cmd_flag_i(cmd_flag_i),
    .last_bit_i(last_bit_i), .busy_i(busy_i), .sleep_req_i(sleep_req_i),
    .force_sleep_o(force_sleep_o), .awake_o(awake_o),
    .cause_tmo_o(cause_tmo_o), .cause_wdg_o(cause_wdg_o)
  );

  task automatic check(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic quiet();
    wake_i = 0; tok_start_i = 0; tok_ok_i = 0; tok_bad_i = 0;
    cmd_flag_i = 0; last_bit_i = 0; busy_i = 0; sleep_req_i = 0;
  endtask

  // Inputs sampled at edge i of a session (edge 0 is the wake edge)
  task automatic drive(input int scn, input int d, input int i);
    quiet();
    case (scn)
      0: tok_ok_i = (i == d);
      1: begin
        tok_ok_i   = (i == 1) || (i > 2 && (i - 2) % d == 0 && (i - 2) / d <= 4);
        cmd_flag_i = (i == 2);
        last_bit_i = (i == 2 + 4 * d);
      end
      2: begin
        tok_ok_i   = (i == 1);
        cmd_flag_i = (i == 2);
        busy_i     = (i >= 3);
      end
      3: begin
        tok_ok_i  = (i == 1) || (i > 2 && i % 2 == 0);
        tok_bad_i = (i == 2);
      end
      4: begin
        tok_ok_i    = (i == 1);
        tok_start_i = (i == 3);
      end
      5: begin
        tok_ok_i = (i == 1) || (i % 7 == 0);
        wake_i   = (i == 10) || (i == 20) || (i == 30);
      end
      6: begin
        tok_ok_i    = (i == 1) || (i == 13);
        sleep_req_i = (i == 8);
        wake_i      = (i == 12);
      end
      7: begin
        tok_ok_i    = (i == 1);
        tok_start_i = (i == WDG - TMO);
      end
      default: ;
    endcase
  endtask

  task automatic run(input int scn, input int d, input int exp_edge,
                     input int etmo, input int ewdg, input string tag);
    int first;
    int pulses;
    first = -1;
    pulses = 0;
    @(negedge clk);
    for (int i = 0; i <= exp_edge + 3; i++) begin
      if (i == 0) begin
        quiet();
        wake_i = 1;
      end else begin
        drive(scn, d, i);
      end
      @(negedge clk);
      if (force_sleep_o) begin
        pulses++;
        if (first < 0) first = i;
      end
      if (i == 0) check({tag, " R1 awake after wake"}, awake_o, 1);
      if (i == 0) check({tag, " R9 causes cleared on wake"}, cause_tmo_o + cause_wdg_o, 0);
      if (scn == 6 && i == 8) check({tag, " R8 asleep after request"}, awake_o, 0);
      if (scn == 6 && i == 8) check({tag, " R8 no pulse on request"}, force_sleep_o, 0);
      if (scn == 6 && i == 12) check({tag, " R8 rewake"}, awake_o, 1);
    end
    quiet();
    check({tag, " fire edge"}, first, exp_edge);
    check({tag, " R9 one pulse"}, pulses, 1);
    check({tag, " R9 asleep after"}, awake_o, 0);
    check({tag, " R9 timeout cause"}, cause_tmo_o, etmo);
    check({tag, " R9 watchdog cause"}, cause_wdg_o, ewdg);
  endtask

  initial begin
    quiet();
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("reset awake", awake_o, 0);
    check("reset pulse", force_sleep_o, 0);
    check("reset causes", cause_tmo_o + cause_wdg_o, 0);

    // R10: strobes while asleep are ignored for longer than the watchdog
    begin
      int seen;
      seen = 0;
      for (int i = 0; i < WDG + 10; i++) begin
        quiet();
        tok_start_i = (i % 3 == 0);
        tok_bad_i = (i % 5 == 0);
        cmd_flag_i = (i % 4 == 1);
        tok_ok_i = (i % 2 == 1);
        sleep_req_i = (i % 6 == 2);
        busy_i = (i % 8 < 4);
        @(negedge clk);
        if (force_sleep_o || awake_o) seen++;
      end
      quiet();
      check("R10 asleep ignores strobes", seen, 0);
    end

    // R2: first-token delay sweep
    for (int d = 1; d <= TMO + 2; d++)
      run(0, d, (d > TMO) ? TMO : WDG, (d > TMO) ? 1 : 0, (d > TMO) ? 0 : 1, "R2 first token");

    // R3/R4: command with inter-token gap sweep
    for (int g = 1; g <= TMO + 2; g++)
      run(1, g, (g > TMO) ? 2 + TMO : WDG, (g > TMO) ? 1 : 0, (g > TMO) ? 0 : 1, "R3 R4 command gap");

    run(2, 0, WDG, 0, 1, "R6 R7 busy");
    run(3, 0, 2 + TMO, 1, 0, "R5 illegal token");
    run(4, 0, 3 + TMO, 1, 0, "R4 token started");
    run(5, 0, WDG, 0, 1, "R1 R7 wake ignored");
    run(6, 0, 12 + WDG, 0, 1, "R8 sleep then wake");
    run(7, 0, WDG, 1, 1, "R9 both expire");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL R7 bench watchdog expired: actual 1 expected 0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule